// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI host that runs one serial-flash command each time software fires it. Software places an opcode in its own register. It programs how many bytes follow the opcode on the way out and how many bytes come back, and loads the outgoing bytes into a 71-byte data buffer. Writing the go bit then starts the command.

The engine lowers chip select and shifts out the opcode and the outgoing bytes. It then clocks in the requested reply bytes and drops them into the same buffer, directly behind the outgoing ones. A busy flag stays up until chip select returns high. Outgoing and returning bytes share the one buffer, so their two counts together may not exceed its depth. A go request that breaks this rule, or that arrives while a command is running, is refused and leaves a sticky error flag.

The serial side is single-bit SPI mode 0, with SCLK derived from the system clock by a fixed even divider. The register side is a byte-addressed read/write bus that acknowledges each request one cycle later.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk and spi_mosi are 0, and every readable byte reads 0 (the opcode register, both count registers, the status byte at 0x4F and the data buffer).
- R2: Writing a byte with bit 7 set to address 0x47 starts a command when the engine is idle and the counts fit. The engine sends the opcode register (address 0x45) first and then the number of bytes given by the send-count register (0x48), taken from buffer entries 0x80 upward. Every byte goes out MSB first.
- R3: After the outgoing bytes, the engine clocks in the number of bytes given by the receive-count register (0x4B) while holding spi_mosi at 0. Returning byte i is stored at address 0x80 + send count + i. The outgoing bytes stay in the buffer unchanged.
- R4: spi_cs_n falls before the first rising SCLK edge and stays low through the whole command. It rises exactly CLK_DIV system clocks after the last falling SCLK edge. spi_sclk is 0 whenever spi_cs_n is 1.
- R5: Status bit 7 of address 0x4F (busy) reads 1 from the cycle after an accepted go write until spi_cs_n rises, and reads 0 after that.
- R6: A go write while send count + receive count exceeds FIFO_DEPTH (71) starts nothing and sets status bit 6 of 0x4F (error).
- R7: A go write while busy starts nothing and sets the error bit. This includes a go write in the final busy cycle.
- R8: While busy, bus writes to the opcode register, the count registers and the data buffer are ignored.
- R9: A write to 0x4F with bit 6 set clears the error bit. A write to 0x47 with bit 7 clear has no effect.
- R10: bus_ack is 1 exactly in the cycle after each bus_req. A read returns its data in that same cycle. Unmapped addresses read 0, and the opcode and count registers read back the values written.
- R11: SCLK stays high for CLK_DIV/2 system clocks and has a period of CLK_DIV system clocks. MOSI changes only while SCLK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Acknowledge, one cycle after bus_req |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The risky overlap is a go write that lands in the same cycle in which the engine ends its tail and drops busy. The go decision must then use the busy value of that cycle, so the write is refused instead of launching a second command. The bench provokes this by holding a go write on the bus every cycle of a running command until it sees spi_cs_n high. It then checks three things: the error bit is set, exactly one chip-select fall happened, and chip select stays high afterwards.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;

    // Buffer address width; the data window occupies 0x80..0xFF.
    localparam int FIFO_AW = 7;

    localparam logic [7:0] A_OPCODE    = 8'h45;
    localparam logic [7:0] A_GO        = 8'h47;
    localparam logic [7:0] A_TXCNT     = 8'h48;
    localparam logic [7:0] A_RXCNT     = 8'h4B;
    localparam logic [7:0] A_STAT_HI   = 8'h4F;
    localparam logic [7:0] A_FIFO_BASE = 8'h80;

    localparam int GO_BIT   = 7;
    localparam int BUSY_BIT = 7;
    localparam int ERR_BIT  = 6;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SHIFT,
        SQ_TAIL
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] ntx;
        logic [7:0] nrx;
    } xfer_cfg_t;

    typedef struct packed {
        logic               en;
        logic [FIFO_AW-1:0] addr;
        logic [7:0]         data;
    } fifo_wr_t;

    function automatic logic counts_fit(input logic [7:0] ntx, input logic [7:0] nrx,
                                        input int depth);
        logic [8:0] sum;
        sum = {1'b0, ntx} + {1'b0, nrx};
        return int'(sum) <= depth;
    endfunction

    function automatic logic in_window(input logic [7:0] addr, input int depth);
        logic [7:0] ofs;
        ofs = addr - A_FIFO_BASE;
        return (addr >= A_FIFO_BASE) && (int'(ofs) < depth);
    endfunction

endpackage

// File: rtl/spi_eng_fifo.sv
`timescale 1ns/1ps
module spi_eng_fifo
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 71
) (
    input  logic               clk,
    input  logic               rst,
    input  fifo_wr_t           wr_bus,
    input  fifo_wr_t           wr_eng,
    input  logic [FIFO_AW-1:0] raddr_bus,
    input  logic [FIFO_AW-1:0] raddr_eng,
    output logic [7:0]         rdata_bus,
    output logic [7:0]         rdata_eng
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_bus.en && int'(wr_bus.addr) < DEPTH) mem[wr_bus.addr] <= wr_bus.data;
            // engine port listed last: it wins a same-entry collision
            if (wr_eng.en && int'(wr_eng.addr) < DEPTH) mem[wr_eng.addr] <= wr_eng.data;
        end
    end

    assign rdata_bus = (int'(raddr_bus) < DEPTH) ? mem[raddr_bus] : 8'h00;
    assign rdata_eng = (int'(raddr_eng) < DEPTH) ? mem[raddr_eng] : 8'h00;

endmodule

// File: rtl/spi_eng_regs.sv
`timescale 1ns/1ps
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 71
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               we,
    input  logic [7:0]         addr,
    input  logic [7:0]         wdata,
    input  logic               busy,
    input  logic [7:0]         fifo_rdata,
    output logic [FIFO_AW-1:0] fifo_raddr,
    output fifo_wr_t           fifo_wr,
    output xfer_cfg_t          cfg,
    output logic               start,
    output logic [7:0]         rdata,
    output logic               ack
);

    xfer_cfg_t  cfg_q;
    logic       err_q;
    logic       wr_any;
    logic       wr_idle;
    logic       go_req;
    logic       fits;
    logic [7:0] stat_hi;
    logic [7:0] rd_mux;

    assign wr_any     = req & we;
    assign wr_idle    = wr_any & ~busy;
    assign fits       = counts_fit(cfg_q.ntx, cfg_q.nrx, DEPTH);
    assign go_req     = wr_any && (addr == A_GO) && wdata[GO_BIT];
    assign start      = go_req && !busy && fits;
    assign cfg        = cfg_q;
    assign fifo_raddr = FIFO_AW'(addr - A_FIFO_BASE);

    assign fifo_wr = '{en:   wr_idle && in_window(addr, DEPTH),
                       addr: fifo_raddr,
                       data: wdata};

    always_comb begin
        stat_hi           = 8'h00;
        stat_hi[BUSY_BIT] = busy;
        stat_hi[ERR_BIT]  = err_q;
    end

    always_comb begin
        if (in_window(addr, DEPTH)) begin
            rd_mux = fifo_rdata;
        end else begin
            case (addr)
                A_OPCODE:  rd_mux = cfg_q.opcode;
                A_TXCNT:   rd_mux = cfg_q.ntx;
                A_RXCNT:   rd_mux = cfg_q.nrx;
                A_STAT_HI: rd_mux = stat_hi;
                default:   rd_mux = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            err_q <= 1'b0;
            ack   <= 1'b0;
            rdata <= 8'h00;
        end else begin
            ack   <= req;
            rdata <= (req && !we) ? rd_mux : 8'h00;
            if (wr_idle) begin
                case (addr)
                    A_OPCODE: cfg_q.opcode <= wdata;
                    A_TXCNT:  cfg_q.ntx    <= wdata;
                    A_RXCNT:  cfg_q.nrx    <= wdata;
                    default:  ;
                endcase
            end
            if (wr_any && (addr == A_STAT_HI) && wdata[ERR_BIT]) err_q <= 1'b0;
            if (go_req && (busy || !fits)) err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_eng_seq.sv
`timescale 1ns/1ps
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  xfer_cfg_t          cfg,
    input  logic [7:0]         fifo_rdata,
    output logic [FIFO_AW-1:0] fifo_raddr,
    output fifo_wr_t           fifo_wr,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               busy
);

    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] TAIL_M1 = CW'(CLK_DIV - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic [7:0]    byte_idx;
    logic [7:0]    ntx;
    logic [7:0]    last_idx;
    logic [7:0]    txsh;
    logic [7:0]    rxsh;
    logic [2:0]    bit_idx;
    logic          tick;
    logic          byte_end;

    assign tick     = (cnt == HALF_M1);
    assign byte_end = (st == SQ_SHIFT) && tick && sclk && (bit_idx == 3'd7);

    // byte b (b>=1) maps to buffer entry b-1 for both directions;
    // during byte b the address b fetches the next outgoing byte
    assign fifo_raddr = FIFO_AW'(byte_idx);
    assign fifo_wr    = '{en:   byte_end && (byte_idx > ntx),
                          addr: FIFO_AW'(byte_idx - 8'd1),
                          data: rxsh};
    assign mosi       = txsh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            byte_idx <= 8'd0;
            ntx      <= 8'd0;
            last_idx <= 8'd0;
            txsh     <= 8'd0;
            rxsh     <= 8'd0;
            bit_idx  <= 3'd0;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            busy     <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st       <= SQ_LEAD;
                        cnt      <= '0;
                        byte_idx <= 8'd0;
                        bit_idx  <= 3'd0;
                        ntx      <= cfg.ntx;
                        last_idx <= cfg.ntx + cfg.nrx;
                        txsh     <= cfg.opcode;
                        cs_n     <= 1'b0;
                        busy     <= 1'b1;
                    end
                end
                SQ_LEAD: begin
                    if (tick) begin
                        cnt  <= '0;
                        sclk <= 1'b1;
                        rxsh <= {rxsh[6:0], miso};
                        st   <= SQ_SHIFT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (!tick) begin
                        cnt <= cnt + 1'b1;
                    end else begin
                        cnt <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                            rxsh <= {rxsh[6:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bit_idx != 3'd7) begin
                                bit_idx <= bit_idx + 3'd1;
                                txsh    <= {txsh[6:0], 1'b0};
                            end else begin
                                bit_idx <= 3'd0;
                                if (byte_idx == last_idx) begin
                                    st   <= SQ_TAIL;
                                    txsh <= 8'd0;
                                end else begin
                                    byte_idx <= byte_idx + 8'd1;
                                    txsh     <= (byte_idx < ntx) ? fifo_rdata : 8'd0;
                                end
                            end
                        end
                    end
                end
                SQ_TAIL: begin
                    if (cnt == TAIL_M1) begin
                        cnt  <= '0;
                        cs_n <= 1'b1;
                        busy <= 1'b0;
                        st   <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int FIFO_DEPTH = 71,
    parameter int CLK_DIV    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_req,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_ack,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    xfer_cfg_t          cfg;
    fifo_wr_t           wr_bus;
    fifo_wr_t           wr_eng;
    logic [FIFO_AW-1:0] raddr_bus;
    logic [FIFO_AW-1:0] raddr_eng;
    logic [7:0]         rdata_bus;
    logic [7:0]         rdata_eng;
    logic               eng_start;
    logic               eng_busy;

    spi_eng_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .busy       (eng_busy),
        .fifo_rdata (rdata_bus),
        .fifo_raddr (raddr_bus),
        .fifo_wr    (wr_bus),
        .cfg        (cfg),
        .start      (eng_start),
        .rdata      (bus_rdata),
        .ack        (bus_ack)
    );

    spi_eng_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_bus    (wr_bus),
        .wr_eng    (wr_eng),
        .raddr_bus (raddr_bus),
        .raddr_eng (raddr_eng),
        .rdata_bus (rdata_bus),
        .rdata_eng (rdata_eng)
    );

    spi_eng_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .cfg        (cfg),
        .fifo_rdata (rdata_eng),
        .fifo_raddr (raddr_eng),
        .fifo_wr    (wr_eng),
        .miso       (spi_miso),
        .cs_n       (spi_cs_n),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .busy       (eng_busy)
    );

endmodule

// File: rtl/spi_eng_chk.sv
`timescale 1ns/1ps
module spi_eng_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic bus_req,
    input logic bus_ack,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic busy
);

    localparam int HALF = CLK_DIV / 2;
    localparam int HW   = $clog2(CLK_DIV) + 2;

    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)       hi_run <= '0;
        else if (sclk) hi_run <= hi_run + 1'b1;
        else           hi_run <= '0;
    end

    p_ack_follows_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack);

    p_ack_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_ack);

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_cs_release_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (!sclk && !$past(sclk)));

    p_busy_cover_r5: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    p_mosi_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk) || (sclk && $past(sclk))) |-> $stable(mosi));

    p_high_time_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_run == HW'(HALF)));

endmodule

bind spi_cmd_engine spi_eng_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_req (bus_req),
    .bus_ack (bus_ack),
    .cs_n    (spi_cs_n),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .busy    (eng_busy)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;

    localparam int      DIV   = 4;
    localparam int      HALF  = DIV / 2;
    localparam int      DEPTH = 71;
    localparam realtime TCK   = 8.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       miso = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_ack;
    logic       cs_n;
    logic       sclk;
    logic       mosi;

    always #4 clk = ~clk;

    spi_cmd_engine #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .spi_cs_n  (cs_n),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_miso  (miso)
    );

    int total = 0;
    int bad = 0;
    int ack_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash-side model ----------------
    logic [7:0] salt = 8'h00;
    logic [7:0] obs [0:79];
    int         bitn = 0;
    int         cs_falls = 0;
    int         tim_bad = 0;
    bit         first_rise = 0;
    bit         seen = 0;
    realtime    t_csf = 0.0;
    realtime    t_rise = 0.0;
    realtime    t_fall = 0.0;

    function automatic logic [7:0] rsp_byte(input int j, input logic [7:0] s);
        return 8'(j * 29) ^ s ^ 8'h5A;
    endfunction

    function automatic logic [7:0] tx_byte(input int i, input logic [7:0] s);
        return 8'(i * 53 + 7) ^ {s[3:0], s[7:4]};
    endfunction

    function automatic logic rsp_bit(input int k);
        logic [7:0] b;
        b = rsp_byte(k / 8, salt);
        return b[7 - (k % 8)];
    endfunction

    always @(negedge cs_n) begin
        cs_falls++;
        bitn = 0;
        first_rise = 1;
        seen = 1;
        t_csf = $realtime;
        miso = rsp_bit(0);
    end

    always @(posedge sclk) begin
        if (first_rise) begin
            if ($realtime - t_csf != HALF * TCK) tim_bad++;
            first_rise = 0;
        end else if ($realtime - t_rise != DIV * TCK) begin
            tim_bad++;
        end
        t_rise = $realtime;
        if (bitn < 640) obs[bitn / 8] = {obs[bitn / 8][6:0], mosi};
        bitn++;
    end

    always @(negedge sclk) begin
        if (seen) begin
            t_fall = $realtime;
            if ($realtime - t_rise != HALF * TCK) tim_bad++;
            if (!cs_n) miso = rsp_bit(bitn);
        end
    end

    always @(posedge cs_n) begin
        if (seen && ($realtime - t_fall != DIV * TCK)) tim_bad++;
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        if (!bus_ack) ack_bad++;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata;
        if (!bus_ack) ack_bad++;
    endtask

    // ---------------- transfer helpers ----------------
    logic [7:0] cur_op;
    int         cur_tx;
    int         cur_rx;

    task automatic start_xfer(input logic [7:0] op, input int tx, input int rx,
                              input logic [7:0] s);
        logic [7:0] d;
        salt = s; cur_op = op; cur_tx = tx; cur_rx = rx;
        wr(8'h45, op);
        wr(8'h48, 8'(tx));
        wr(8'h4B, 8'(rx));
        for (int i = 0; i < tx; i++) wr(8'(8'h80 + i), tx_byte(i, s));
        tim_bad = 0;
        wr(8'h47, 8'h80);
        rd(8'h4F, d);
        check(d[7] == 1'b1, "R5 busy after go", int'(d[7]), 1);
    endtask

    task automatic finish_xfer(input logic [7:0] exp_stat);
        logic [7:0] d;
        int mm_tx, mm_z, mm_rx, mm_keep;
        while (!cs_n) @(negedge clk);
        rd(8'h4F, d);
        check(d == exp_stat, "R5 status after end", int'(d), int'(exp_stat));
        check(bitn == 8 * (1 + cur_tx + cur_rx), "R2 bit count", bitn, 8 * (1 + cur_tx + cur_rx));
        check(obs[0] == cur_op, "R2 opcode first", int'(obs[0]), int'(cur_op));
        mm_tx = 0; mm_z = 0; mm_rx = 0; mm_keep = 0;
        for (int i = 0; i < cur_tx; i++)
            if (obs[1 + i] != tx_byte(i, salt)) mm_tx++;
        for (int i = 0; i < cur_rx; i++)
            if (obs[1 + cur_tx + i] != 8'h00) mm_z++;
        check(mm_tx == 0, "R2 outgoing bytes", mm_tx, 0);
        check(mm_z == 0, "R3 mosi low in receive", mm_z, 0);
        for (int i = 0; i < cur_rx; i++) begin
            rd(8'(8'h80 + cur_tx + i), d);
            if (d != rsp_byte(1 + cur_tx + i, salt)) mm_rx++;
        end
        check(mm_rx == 0, "R3 received bytes placed", mm_rx, 0);
        for (int i = 0; i < cur_tx; i++) begin
            rd(8'(8'h80 + i), d);
            if (d != tx_byte(i, salt)) mm_keep++;
        end
        check(mm_keep == 0, "R3 outgoing bytes kept", mm_keep, 0);
        check(tim_bad == 0, "R4 R11 serial timing", tim_bad, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] d;
        int n0;
        int tx, rx;
        int unused_seed;
        unused_seed = $urandom(32'h1234_5678);

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check(cs_n == 1 && sclk == 0 && mosi == 0, "R1 pins idle",
              int'({cs_n, sclk, mosi}), 3'b100);
        rd(8'h4F, d); check(d == 8'h00, "R1 status", int'(d), 0);
        rd(8'h45, d); check(d == 8'h00, "R1 opcode", int'(d), 0);
        rd(8'h48, d); check(d == 8'h00, "R1 send count", int'(d), 0);
        rd(8'h80, d); check(d == 8'h00, "R1 buffer", int'(d), 0);

        // R10 readback and unmapped
        rd(8'h10, d); check(d == 8'h00, "R10 unmapped", int'(d), 0);
        wr(8'h45, 8'hA5);
        rd(8'h45, d); check(d == 8'hA5, "R10 readback", int'(d), 8'hA5);

        // directed corner transfers
        start_xfer(8'h9F, 0, 0, 8'h01);  finish_xfer(8'h00);
        start_xfer(8'h03, 71, 0, 8'h02); finish_xfer(8'h00);
        start_xfer(8'h0B, 0, 71, 8'h03); finish_xfer(8'h00);
        start_xfer(8'h02, 40, 31, 8'h04); finish_xfer(8'h00);

        // R6 overflow refused
        n0 = cs_falls;
        wr(8'h48, 8'd40); wr(8'h4B, 8'd32); wr(8'h47, 8'h80);
        repeat (60) @(negedge clk);
        check(cs_falls == n0, "R6 no transfer on overflow", cs_falls - n0, 0);
        rd(8'h4F, d); check(d == 8'h40, "R6 error set", int'(d), 8'h40);

        // R9 clear and go bit clear
        wr(8'h4F, 8'h40);
        rd(8'h4F, d); check(d == 8'h00, "R9 error cleared", int'(d), 0);
        wr(8'h48, 8'd1); wr(8'h4B, 8'd1); wr(8'h47, 8'h7F);
        repeat (40) @(negedge clk);
        check(cs_falls == n0, "R9 go bit clear ignored", cs_falls - n0, 0);
        rd(8'h4F, d); check(d == 8'h00, "R9 status unchanged", int'(d), 0);

        // R7 / R8 writes while busy
        n0 = cs_falls;
        start_xfer(8'h3B, 3, 2, 8'h05);
        wr(8'h45, 8'h11); wr(8'h48, 8'd9); wr(8'h80, 8'hEE); wr(8'h47, 8'h80);
        finish_xfer(8'h40);
        check(cs_falls == n0 + 1, "R7 single transfer", cs_falls - n0, 1);
        rd(8'h45, d); check(d == 8'h3B, "R8 opcode kept", int'(d), 8'h3B);
        rd(8'h48, d); check(d == 8'd3, "R8 count kept", int'(d), 3);
        wr(8'h4F, 8'h40);

        // R7 go held through the final busy cycle
        start_xfer(8'h05, 1, 1, 8'h06);
        n0 = cs_falls;
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = 8'h47; bus_wdata = 8'h80;
        while (!cs_n) @(negedge clk);
        bus_req = 0; bus_we = 0;
        repeat (30) @(negedge clk);
        check(cs_n == 1 && cs_falls == n0, "R7 go in last busy cycle refused",
              cs_falls - n0, 0);
        finish_xfer(8'h40);
        wr(8'h4F, 8'h40);

        // constrained random transfers
        for (int k = 0; k < 10; k++) begin
            tx = int'($urandom_range(0, DEPTH));
            rx = int'($urandom_range(0, DEPTH - tx));
            start_xfer(8'($urandom), tx, rx, 8'($urandom));
            finish_xfer(8'h00);
        end

        check(ack_bad == 0, "R10 ack after each request", ack_bad, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule